// File: doc/BRIEF.md
# FSK Tag Waveform Generator

This block produces the load-modulation sample stream that a card emulator drives onto its coil to imitate a low-frequency identification tag. Each sample is one bit: 1 leaves the coil open and 0 shorts it. Each bit of a 44-bit identifier becomes two halves. One half is a burst of the short-period tone, 8 samples per period. The other half is a burst of the long-period tone, 10 samples per period. The order of the two halves carries the bit value.

A frame opens with a start marker built from half sequences that no valid bit can produce. The identifier bits follow, most significant first. One short-tone period is placed before every group of four bits. The frame repeats for as long as the block is enabled. The generator moves one sample forward on every field-clock tick. Dropping enable silences the output and sends the position back to the start of the frame.

Top module: `fsk_tag_wavegen`

## Requirements
- R1: While en_i is low, coil_o is 0 and the frame position is held at the start. The first tick after en_i rises outputs the first sample of the start marker, so a mid-frame disable followed by re-enable restarts the frame.
- R2: A short-tone half is 6 periods of 8 samples each, 48 samples in all. Each period starts with 2 samples of 1 and ends with 6 samples of 0.
- R3: A long-tone half is 5 periods of 10 samples each, 50 samples in all. Each period starts with 3 samples of 1 and ends with 7 samples of 0.
- R4: A frame begins with eight halves in this order: short, short, short, long, long, long, short, long.
- R5: A data bit of 1 is sent as a short half followed by a long half. A data bit of 0 is sent as a long half followed by a short half.
- R6: The identifier bits are sent from id bit 43 down to id bit 0.
- R7: One spacer period of 8 samples (1,1,0,0,0,0,0,0) comes before each bit whose index modulo 4 is 3, that is before bits 43, 39, and so on down to 3.
- R8: A frame is 4792 samples long. The start marker follows the second half of bit 0 directly, with no extra samples in between.
- R9: The position advances only on a cycle where tick_i is high. With en_i high and tick_i low, coil_o keeps its value.
- R10: The identifier is captured while disabled and again at each frame wrap. A change of id_i in the middle of a frame first appears in the next frame.
- R11: coil_o is registered. The sample selected by a tick appears after that clock edge, not in the cycle the tick is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears the output and the position |
| tick_i | input | 1 | Field-clock strobe, one sample per high cycle |
| id_i | input | 44 | Identifier to transmit |
| coil_o | output | 1 | Coil load sample: 1 open, 0 shorted |

## Verification
The bench builds the generator with its default parameters: a 44-bit identifier, groups of four, and periods of 8 and 10 samples. At these values a whole 4792-sample frame fits in a few thousand cycles. The bench can therefore walk every start-marker half, every spacer and every data half, and cross the wrap into the following frame. The same frames are also replayed with two idle cycles between ticks, which exercises the hold behaviour on every sample.

// File: rtl/fsk_wave_pkg.sv
package fsk_wave_pkg;
  typedef enum logic {TONE_SHORT = 1'b0, TONE_LONG = 1'b1} tone_e;
  typedef enum logic [1:0] {SEQ_SOF, SEQ_GAP, SEQ_BIT} seq_e;
  // bit i set: start-marker half i uses the long tone
  localparam logic [7:0] SOF_LONG_MASK = 8'b1011_1000;
endpackage

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen
  import fsk_wave_pkg::*;
#(
  parameter int SHORT_PER  = 8,
  parameter int SHORT_HIGH = 2,
  parameter int LONG_PER   = 10,
  parameter int LONG_HIGH  = 3,
  parameter int REP_W      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  tone_e            tone_i,
  input  logic [REP_W-1:0] reps_i,
  output logic             level_o,
  output logic             last_o
);
  localparam int MAX_PER = (LONG_PER > SHORT_PER) ? LONG_PER : SHORT_PER;
  localparam int PER_W   = $clog2(MAX_PER);

  logic [PER_W-1:0] ph_q;
  logic [REP_W-1:0] rp_q;
  logic [PER_W-1:0] per_m1, high;
  logic             ph_last, rp_last;

  assign per_m1  = (tone_i == TONE_LONG) ? PER_W'(LONG_PER - 1) : PER_W'(SHORT_PER - 1);
  assign high    = (tone_i == TONE_LONG) ? PER_W'(LONG_HIGH) : PER_W'(SHORT_HIGH);
  assign ph_last = (ph_q == per_m1);
  assign rp_last = (rp_q == reps_i - 1'b1);
  assign level_o = (ph_q < high);
  assign last_o  = ph_last && rp_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
      rp_q <= '0;
    end else if (clr_i) begin
      ph_q <= '0;
      rp_q <= '0;
    end else if (adv_i) begin
      if (ph_last) begin
        ph_q <= '0;
        rp_q <= rp_last ? '0 : rp_q + 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsk_frame_seq.sv
module fsk_frame_seq
  import fsk_wave_pkg::*;
#(
  parameter int ID_W  = 44,
  parameter int GROUP = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            adv_i,
  input  logic [ID_W-1:0] id_i,
  output tone_e           tone_o,
  output logic            gap_o,
  output logic            wrap_o
);
  localparam int BIT_W = $clog2(ID_W);

  seq_e             seq_q;
  logic [2:0]       sof_q;
  logic [BIT_W-1:0] bit_q;
  logic             half_q;
  logic [ID_W-1:0]  id_q;
  logic             cur_bit;

  function automatic logic gap_before(input logic [BIT_W-1:0] b);
    return (int'(b) % GROUP) == (GROUP - 1);
  endfunction

  assign cur_bit = id_q[bit_q];
  assign gap_o   = (seq_q == SEQ_GAP);
  assign wrap_o  = (seq_q == SEQ_BIT) && half_q && (bit_q == '0);

  always_comb begin
    unique case (seq_q)
      SEQ_SOF: tone_o = tone_e'(SOF_LONG_MASK[sof_q]);
      SEQ_GAP: tone_o = TONE_SHORT;
      default: tone_o = tone_e'(half_q ^ ~cur_bit); // bit 1: short then long
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q  <= SEQ_SOF;
      sof_q  <= '0;
      bit_q  <= '0;
      half_q <= 1'b0;
      id_q   <= '0;
    end else if (clr_i) begin
      seq_q  <= SEQ_SOF;
      sof_q  <= '0;
      bit_q  <= '0;
      half_q <= 1'b0;
      id_q   <= id_i;
    end else if (adv_i) begin
      unique case (seq_q)
        SEQ_SOF: begin
          if (sof_q == 3'd7) begin
            bit_q  <= BIT_W'(ID_W - 1);
            half_q <= 1'b0;
            seq_q  <= gap_before(BIT_W'(ID_W - 1)) ? SEQ_GAP : SEQ_BIT;
          end else begin
            sof_q <= sof_q + 1'b1;
          end
        end
        SEQ_GAP: begin
          seq_q  <= SEQ_BIT;
          half_q <= 1'b0;
        end
        default: begin
          if (!half_q) begin
            half_q <= 1'b1;
          end else if (bit_q == '0) begin
            seq_q  <= SEQ_SOF;
            sof_q  <= '0;
            half_q <= 1'b0;
            id_q   <= id_i;
          end else begin
            bit_q  <= bit_q - 1'b1;
            half_q <= 1'b0;
            seq_q  <= gap_before(bit_q - 1'b1) ? SEQ_GAP : SEQ_BIT;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fsk_tag_wavegen.sv
module fsk_tag_wavegen
  import fsk_wave_pkg::*;
#(
  parameter int ID_W       = 44,
  parameter int GROUP      = 4,
  parameter int SHORT_PER  = 8,
  parameter int SHORT_HIGH = 2,
  parameter int SHORT_REP  = 6,
  parameter int LONG_PER   = 10,
  parameter int LONG_HIGH  = 3,
  parameter int LONG_REP   = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            tick_i,
  input  logic [ID_W-1:0] id_i,
  output logic            coil_o
);
  localparam int MAX_REP = (LONG_REP > SHORT_REP) ? LONG_REP : SHORT_REP;
  localparam int REP_W   = $clog2(MAX_REP + 1);

  tone_e            tone;
  logic             gap, wrap, level, seg_last, adv, clr;
  logic [REP_W-1:0] seg_reps;

  assign adv      = en_i & tick_i;
  assign clr      = ~en_i;
  assign seg_reps = gap ? REP_W'(1) :
                    (tone == TONE_LONG) ? REP_W'(LONG_REP) : REP_W'(SHORT_REP);

  fsk_frame_seq #(
    .ID_W  (ID_W),
    .GROUP (GROUP)
  ) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .adv_i  (adv & seg_last),
    .id_i   (id_i),
    .tone_o (tone),
    .gap_o  (gap),
    .wrap_o (wrap)
  );

  fsk_tone_gen #(
    .SHORT_PER  (SHORT_PER),
    .SHORT_HIGH (SHORT_HIGH),
    .LONG_PER   (LONG_PER),
    .LONG_HIGH  (LONG_HIGH),
    .REP_W      (REP_W)
  ) i_tone (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .adv_i   (adv),
    .tone_i  (tone),
    .reps_i  (seg_reps),
    .level_o (level),
    .last_o  (seg_last)
  );

  logic unused_wrap;
  assign unused_wrap = wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     coil_o <= 1'b0;
    else if (!en_i)  coil_o <= 1'b0;
    else if (tick_i) coil_o <= level;
  end
endmodule

// File: rtl/fsk_tag_wavegen_chk.sv
module fsk_tag_wavegen_chk #(
  parameter int SHORT_PER  = 8,
  parameter int SHORT_HIGH = 2,
  parameter int LONG_PER   = 10,
  parameter int LONG_HIGH  = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic tick_i,
  input logic coil_o
);
  localparam int MAX_ONES  = (LONG_HIGH > SHORT_HIGH) ? LONG_HIGH : SHORT_HIGH;
  localparam int MAX_ZEROS = ((LONG_PER - LONG_HIGH) > (SHORT_PER - SHORT_HIGH)) ?
                             (LONG_PER - LONG_HIGH) : (SHORT_PER - SHORT_HIGH);

  logic       upd_q, en_q;
  logic [7:0] run1_q, run0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q  <= 1'b0;
      en_q   <= 1'b1;
      run1_q <= '0;
      run0_q <= '0;
    end else begin
      upd_q <= en_i & tick_i;
      en_q  <= en_i;
      if (!en_i) begin
        run1_q <= '0;
        run0_q <= '0;
      end else if (upd_q) begin
        if (coil_o) begin
          run1_q <= (run1_q == 8'hff) ? run1_q : run1_q + 1'b1;
          run0_q <= '0;
        end else begin
          run0_q <= (run0_q == 8'hff) ? run0_q : run0_q + 1'b1;
          run1_q <= '0;
        end
      end
    end
  end

  p_idle_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !coil_o);
  p_restart_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !en_q) |=> coil_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(coil_o));
  p_ones_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run1_q <= 8'(MAX_ONES));
  p_zeros_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run0_q <= 8'(MAX_ZEROS));
endmodule

bind fsk_tag_wavegen fsk_tag_wavegen_chk #(
  .SHORT_PER  (SHORT_PER),
  .SHORT_HIGH (SHORT_HIGH),
  .LONG_PER   (LONG_PER),
  .LONG_HIGH  (LONG_HIGH)
) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .tick_i (tick_i),
  .coil_o (coil_o)
);

// File: tb/test_fsk_tag_wavegen.sv
module test_fsk_tag_wavegen;
  localparam int ID_W = 44;
  localparam int FRAME_LEN = 4792;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            en_i = 1'b0;
  logic            tick_i = 1'b0;
  logic [ID_W-1:0] id_i = '0;
  logic            coil_o;

  int n_chk = 0, n_fail = 0, gap = 0, hold_bad = 0, smp_cnt = 0;

  always #10 clk_i = ~clk_i;

  fsk_tag_wavegen i_fsk_tag_wavegen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tick_i (tick_i),
    .id_i   (id_i),
    .coil_o (coil_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick_get(output logic s);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    s = coil_o;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk_i);
      if (coil_o !== s) hold_bad++;
    end
  endtask

  task automatic seg(input bit lng, input int reps, input string req);
    int per, high, bad, first_act, first_exp;
    logic s;
    per = lng ? 10 : 8;
    high = lng ? 3 : 2;
    bad = 0; first_act = 0; first_exp = 0;
    for (int r = 0; r < reps; r++)
      for (int p = 0; p < per; p++) begin
        tick_get(s);
        smp_cnt++;
        if (s !== logic'(p < high)) begin
          if (bad == 0) begin first_act = int'(s); first_exp = int'(p < high); end
          bad++;
        end
      end
    check(bad == 0, req, "segment first bad sample", first_act, first_exp);
  endtask

  function automatic int reps_of(input bit lng);
    return lng ? 5 : 6;
  endfunction

  task automatic play_frame(input logic [ID_W-1:0] id, input int chg_bit,
                            input logic [ID_W-1:0] new_id);
    bit sof [8] = '{0, 0, 0, 1, 1, 1, 0, 1};
    smp_cnt = 0;
    for (int i = 0; i < 8; i++)
      seg(sof[i], reps_of(sof[i]), (i == 0) ? "R2" : (i == 3) ? "R3" : "R4");
    for (int b = ID_W - 1; b >= 0; b--) begin
      bit v;
      if (b == chg_bit) id_i = new_id;
      if (b % 4 == 3) seg(1'b0, 1, "R7");
      v = id[b];
      seg(!v, reps_of(!v), (b == ID_W - 1) ? "R6" : "R5");
      seg(v, reps_of(v), (b == ID_W - 1) ? "R6" : "R5");
    end
    check(smp_cnt == FRAME_LEN, "R8", "frame length", smp_cnt, FRAME_LEN);
  endtask

  task automatic start(input logic [ID_W-1:0] id);
    id_i = id;
    @(negedge clk_i);
    en_i = 1'b1;
  endtask

  task automatic stop();
    en_i = 1'b0;
    tick_i = 1'b0;
    @(negedge clk_i);
    check(coil_o === 1'b0, "R1", "coil after disable", int'(coil_o), 0);
  endtask

  task automatic t_reset();
    check(coil_o === 1'b0, "R1", "coil after reset", int'(coil_o), 0);
    for (int i = 0; i < 5; i++) begin
      tick_i = 1'b1;
      @(negedge clk_i);
      check(coil_o === 1'b0, "R1", "coil with ticks while disabled", int'(coil_o), 0);
    end
    tick_i = 1'b0;
  endtask

  task automatic t_registered();
    start(44'h123_4567_89AB);
    tick_i = 1'b1;
    #1;
    check(coil_o === 1'b0, "R11", "coil before tick edge", int'(coil_o), 0);
    @(posedge clk_i);
    #1;
    check(coil_o === 1'b1, "R11", "coil after tick edge", int'(coil_o), 1);
    @(negedge clk_i);
    tick_i = 1'b0;
    stop();
  endtask

  task automatic t_basic();
    start(44'hA5C_3F01_927E);
    play_frame(44'hA5C_3F01_927E, -1, '0);
    seg(1'b0, 6, "R8");
    stop();
  endtask

  task automatic t_gapped();
    gap = 2;
    hold_bad = 0;
    start(44'h6D2_E8B4_1C97);
    play_frame(44'h6D2_E8B4_1C97, -1, '0);
    check(hold_bad == 0, "R9", "changes between ticks", hold_bad, 0);
    gap = 0;
    stop();
  endtask

  task automatic t_disable_mid();
    start(44'hFFF_FFFF_FFFF);
    seg(1'b0, 6, "R4");
    seg(1'b0, 6, "R4");
    stop();
    for (int i = 0; i < 3; i++) begin
      tick_i = 1'b1;
      @(negedge clk_i);
      check(coil_o === 1'b0, "R1", "coil disabled mid-frame", int'(coil_o), 0);
    end
    tick_i = 1'b0;
    en_i = 1'b1;
    play_frame(44'hFFF_FFFF_FFFF, -1, '0);
    stop();
  endtask

  task automatic t_id_change();
    start(44'h5A5_0F0F_3C3C);
    play_frame(44'h5A5_0F0F_3C3C, 20, 44'h000_0000_0000);
    play_frame(44'h000_0000_0000, -1, '0);
    check(1'b1, "R10", "id change applied at next frame", 0, 0);
    stop();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_registered();
    t_basic();
    t_gapped();
    t_disable_mid();
    t_id_change();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule